// File: doc/BRIEF.md
# Skew Calibration Edge Finder

This controller finds where a clock-skew timing-error indicator turns on and off as a tag offset is swept across one beat period. It then places the offset in the middle of the error-free window. Each probe step has a fixed order. The controller writes the offset and waits a settling interval. It then pulses a clear on the error indicator, waits an accumulation interval and takes one sample of the flag. Each sample goes to a three-state deglitcher. That deglitcher needs a run of stable samples before an edge is accepted and another run after it, and it slides the recorded edge forward whenever a sample disagrees.

Each calibration runs two searches. The first looks for the flag to rise and the second for it to fall. From the two edges the controller computes the centre of the working window, which wraps around the end of the beat period, and writes that centre as the final offset. A search that finds nothing within one full period of steps ends the calibration with a failure indication. The circuit that produces the error flag lies outside this block.

Sequencer states: `SQ_IDLE` (waits for start), `SQ_WRITE` (drives the offset, advances the accumulator), `SQ_SETTLE` (settling wait), `SQ_CLEAR` (clear pulse to the flag), `SQ_ACCUM` (accumulation wait), `SQ_SAMPLE` (feeds the flag to the deglitcher), `SQ_JUDGE` (decides: next step, second search, centre or failure), `SQ_CENTRE` (writes the result), `SQ_DONE` and `SQ_FAIL` (terminal, held). Transitions: IDLE/DONE/FAIL→WRITE on start; WRITE→SETTLE; SETTLE→CLEAR on timer expiry; CLEAR→ACCUM; ACCUM→SAMPLE on timer expiry; SAMPLE→JUDGE; JUDGE→WRITE (edge not yet found and step budget left, or rising edge found); JUDGE→CENTRE (falling edge found); JUDGE→FAIL (budget used up); CENTRE→DONE. Deglitcher states: `DG_HUNT`→`DG_ARMED` after STABLE consecutive samples that disagree with the target; `DG_ARMED`→`DG_LOCKED` on the first sample that matches; `DG_LOCKED` sets found after STABLE consecutive matches.

Top module: `skew_edge_finder`

## Requirements
- R1: After reset the block is idle. busy, done, fail, offset_wr and err_clr are low and offset_o is 0.
- R2: A start from idle, done or fail begins a search with accumulator 0, so the first offset written is 0. Every write in a search advances the accumulator by STEP (default 8), and offset_o equals the accumulator modulo P = 2^PERIOD_W. offset_o changes only in the cycle after offset_wr is high.
- R3: In each step, err_clr pulses exactly SETTLE_CYC+2 cycles after the offset_wr pulse. One sample of err_flag follows in every step.
- R4: In DG_HUNT, a sample that differs from the target increments a run counter and a matching sample clears it. When the run reaches STABLE (default 10), the deglitcher moves to DG_ARMED with the run cleared. The run counter never exceeds STABLE.
- R5: In DG_ARMED, the first sample equal to the target moves to DG_LOCKED and records as the edge the accumulator value after that step's advance, which is the written offset plus STEP.
- R6: In DG_LOCKED, a sample that differs from the target adds STEP to the recorded edge and clears the run. STABLE matching samples in a row complete the search.
- R7: The first search targets a high flag (rising edge). The second search targets a low flag (falling edge) and begins by writing again the last offset written in the first search.
- R8: On success the block writes, as one further write, final = (fall + (P − (fall − rise))/2) mod P, with the division truncating toward zero. It then enters DONE.
- R9: A search that has not completed after P/STEP steps ends in FAIL with no centre write.
- R10: A start while busy is ignored.
- R11: done and fail stay high, and offset_o stays unchanged, until the next start. The cycle after that start shows busy high and done and fail low.
- R12: done and fail are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration (single-cycle pulse) |
| err_flag | input | 1 | Timing-error indicator being probed |
| err_clr | output | 1 | Clear pulse sent to the error indicator |
| offset_wr | output | 1 | offset_o takes a new value at the end of this cycle |
| offset_o | output | PERIOD_W | Tag offset being applied |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Calibration succeeded (held) |
| fail | output | 1 | A search ran out of steps (held) |

## Verification
On every cycle, the embedded properties watch the bound on the run counter, the exact edge slide on a disagreeing sample, and the capture of the edge when the deglitcher arms. They also check that offset_o holds between writes, that done and fail are exclusive, and that the step count stays within its budget. Only the bench's scenarios can show the end-to-end results. These are the full sequence of written offsets, including the rewrite at the start of the second search, the settle gap before each clear, and the centre value for plain, wrapping and glitched windows. The scenarios also show the failure when the flag never changes and that a start pulse in mid-run has no effect.

// File: rtl/sef_pkg.sv
package sef_pkg;

    // Deglitcher states
    typedef enum logic [1:0] {
        DG_HUNT   = 2'd0,
        DG_ARMED  = 2'd1,
        DG_LOCKED = 2'd2
    } dg_state_t;

    // Sequencer states
    typedef enum logic [3:0] {
        SQ_IDLE   = 4'd0,
        SQ_WRITE  = 4'd1,
        SQ_SETTLE = 4'd2,
        SQ_CLEAR  = 4'd3,
        SQ_ACCUM  = 4'd4,
        SQ_SAMPLE = 4'd5,
        SQ_JUDGE  = 4'd6,
        SQ_CENTRE = 4'd7,
        SQ_DONE   = 4'd8,
        SQ_FAIL   = 4'd9
    } sq_state_t;

    // Which search is running
    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } phase_t;

endpackage

// File: rtl/sef_wait_timer.sv
module sef_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0) && !load;

endmodule

// File: rtl/sef_deglitch.sv
module sef_deglitch
    import sef_pkg::*;
#(
    parameter int EDGE_W = 17,
    parameter int STEP   = 8,
    parameter int STABLE = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              target,
    input  logic              sample_vld,
    input  logic              sample,
    input  logic [EDGE_W-1:0] cur_ofs,
    output logic              found,
    output logic [EDGE_W-1:0] edge_pos
);

    localparam int RUN_W = $clog2(STABLE + 1);
    localparam logic [RUN_W-1:0]  RUN_MAX = RUN_W'(STABLE);
    localparam logic [EDGE_W-1:0] STEP_V  = EDGE_W'(STEP);

    dg_state_t         st_q, st_d;
    logic [RUN_W-1:0]  run_q, run_d, run_inc;
    logic [EDGE_W-1:0] edge_q, edge_d;
    logic              found_q, found_d;
    logic              hit;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= DG_HUNT;
            run_q   <= '0;
            edge_q  <= '0;
            found_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            run_q   <= run_d;
            edge_q  <= edge_d;
            found_q <= found_d;
        end
    end

    // Next-state and datapath
    always_comb begin
        st_d    = st_q;
        run_d   = run_q;
        edge_d  = edge_q;
        found_d = found_q;
        hit     = (sample == target);
        run_inc = run_q + 1'b1;
        if (clear) begin
            st_d    = DG_HUNT;
            run_d   = '0;
            edge_d  = '0;
            found_d = 1'b0;
        end else if (sample_vld && !found_q) begin
            unique case (st_q)
                DG_HUNT: begin
                    if (hit) begin
                        run_d = '0;
                    end else if (run_inc >= RUN_MAX) begin
                        st_d  = DG_ARMED;
                        run_d = '0;
                    end else begin
                        run_d = run_inc;
                    end
                end
                DG_ARMED: begin
                    if (hit) begin
                        st_d   = DG_LOCKED;
                        edge_d = cur_ofs;
                    end
                end
                DG_LOCKED: begin
                    if (!hit) begin
                        edge_d = edge_q + STEP_V;
                        run_d  = '0;
                    end else begin
                        run_d = run_inc;
                        if (run_inc >= RUN_MAX) begin
                            found_d = 1'b1;
                        end
                    end
                end
                default: st_d = DG_HUNT;
            endcase
        end
    end

    assign found    = found_q;
    assign edge_pos = edge_q;

    // R4: run counter bounded by the stability threshold
    p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_MAX);

    // R5: arming capture records the advanced offset
    p_armed_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DG_ARMED && sample_vld && sample == target && !clear && !found_q)
        |=> (st_q == DG_LOCKED && edge_q == $past(cur_ofs)));

    // R6: disagreeing sample while locked slides the edge by one step
    p_edge_slide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DG_LOCKED && sample_vld && sample != target && !clear && !found_q)
        |=> (edge_q == EDGE_W'($past(edge_q) + STEP_V) && run_q == '0));

endmodule

// File: rtl/sef_centre.sv
module sef_centre #(
    parameter int PERIOD_W = 15,
    parameter int EDGE_W   = 17
) (
    input  logic [EDGE_W-1:0]   rise_pos,
    input  logic [EDGE_W-1:0]   fall_pos,
    output logic [PERIOD_W-1:0] centre
);

    localparam int SW = EDGE_W + 2;
    localparam logic signed [SW-1:0] PERIOD_S = SW'(64'd1 << PERIOD_W);

    logic signed [SW-1:0] rise_s, fall_s, span, width, adj, half, total;
    logic                 unused_hi;

    always_comb begin
        rise_s = $signed({2'b00, rise_pos});
        fall_s = $signed({2'b00, fall_pos});
        span   = fall_s - rise_s;
        width  = PERIOD_S - span;
        // truncate toward zero on halving
        adj    = width + $signed({{(SW-1){1'b0}}, width[SW-1]});
        half   = adj >>> 1;
        total  = fall_s + half;
    end

    assign centre    = total[PERIOD_W-1:0];
    assign unused_hi = ^total[SW-1:PERIOD_W];

endmodule

// File: rtl/skew_edge_finder.sv
module skew_edge_finder
    import sef_pkg::*;
#(
    parameter int PERIOD_W   = 15,
    parameter int STEP       = 8,
    parameter int STABLE     = 10,
    parameter int SETTLE_CYC = 20000,
    parameter int ACCUM_CYC  = 5000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                err_flag,
    output logic                err_clr,
    output logic                offset_wr,
    output logic [PERIOD_W-1:0] offset_o,
    output logic                busy,
    output logic                done,
    output logic                fail
);

    localparam int EDGE_W    = PERIOD_W + 2;
    localparam int MAX_STEPS = (1 << PERIOD_W) / STEP;
    localparam int STEPS_W   = $clog2(MAX_STEPS + 1);
    localparam int TMR_MAX   = (SETTLE_CYC > ACCUM_CYC) ? SETTLE_CYC : ACCUM_CYC;
    localparam int TMR_W     = $clog2(TMR_MAX + 1);
    localparam logic [STEPS_W-1:0] MAX_STEPS_V = STEPS_W'(MAX_STEPS);
    localparam logic [EDGE_W-1:0]  STEP_V      = EDGE_W'(STEP);
    localparam logic [TMR_W-1:0]   SETTLE_V    = TMR_W'(SETTLE_CYC);
    localparam logic [TMR_W-1:0]   ACCUM_V     = TMR_W'(ACCUM_CYC);

    sq_state_t           st_q, st_d;
    phase_t              phase_q;
    logic [EDGE_W-1:0]   acc_q;
    logic [STEPS_W-1:0]  steps_q;
    logic [EDGE_W-1:0]   rise_q;
    logic [PERIOD_W-1:0] ofs_q;
    logic                tmr_load, tmr_exp;
    logic [TMR_W-1:0]    tmr_val;
    logic                dg_clear, dg_vld, dg_found;
    logic [EDGE_W-1:0]   dg_edge;
    logic [PERIOD_W-1:0] centre_v;
    logic                idle_like, go;

    sef_wait_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    sef_deglitch #(.EDGE_W(EDGE_W), .STEP(STEP), .STABLE(STABLE)) u_dg (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (dg_clear),
        .target     (phase_q == PH_RISE),
        .sample_vld (dg_vld),
        .sample     (err_flag),
        .cur_ofs    (acc_q),
        .found      (dg_found),
        .edge_pos   (dg_edge)
    );

    sef_centre #(.PERIOD_W(PERIOD_W), .EDGE_W(EDGE_W)) u_centre (
        .rise_pos (rise_q),
        .fall_pos (dg_edge),
        .centre   (centre_v)
    );

    assign idle_like = (st_q == SQ_IDLE) || (st_q == SQ_DONE) || (st_q == SQ_FAIL);
    assign go        = idle_like && start;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE, SQ_DONE, SQ_FAIL: if (start) st_d = SQ_WRITE;
            SQ_WRITE:  st_d = SQ_SETTLE;
            SQ_SETTLE: if (tmr_exp) st_d = SQ_CLEAR;
            SQ_CLEAR:  st_d = SQ_ACCUM;
            SQ_ACCUM:  if (tmr_exp) st_d = SQ_SAMPLE;
            SQ_SAMPLE: st_d = SQ_JUDGE;
            SQ_JUDGE: begin
                if (dg_found) begin
                    st_d = (phase_q == PH_RISE) ? SQ_WRITE : SQ_CENTRE;
                end else if (steps_q >= MAX_STEPS_V) begin
                    st_d = SQ_FAIL;
                end else begin
                    st_d = SQ_WRITE;
                end
            end
            SQ_CENTRE: st_d = SQ_DONE;
            default:   st_d = SQ_IDLE;
        endcase
    end

    // Outputs and control strobes
    always_comb begin
        offset_wr = (st_q == SQ_WRITE) || (st_q == SQ_CENTRE);
        err_clr   = (st_q == SQ_CLEAR);
        dg_vld    = (st_q == SQ_SAMPLE);
        tmr_load  = (st_q == SQ_WRITE) || (st_q == SQ_CLEAR);
        tmr_val   = (st_q == SQ_CLEAR) ? ACCUM_V : SETTLE_V;
        dg_clear  = go || ((st_q == SQ_JUDGE) && dg_found && (phase_q == PH_RISE));
        busy      = !idle_like;
        done      = (st_q == SQ_DONE);
        fail      = (st_q == SQ_FAIL);
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RISE;
            acc_q   <= '0;
            steps_q <= '0;
            rise_q  <= '0;
            ofs_q   <= '0;
        end else begin
            if (go) begin
                phase_q <= PH_RISE;
                acc_q   <= '0;
                steps_q <= '0;
            end
            if (st_q == SQ_WRITE) begin
                ofs_q   <= acc_q[PERIOD_W-1:0];
                acc_q   <= acc_q + STEP_V;
                steps_q <= steps_q + 1'b1;
            end
            if ((st_q == SQ_JUDGE) && dg_found && (phase_q == PH_RISE)) begin
                rise_q  <= dg_edge;
                phase_q <= PH_FALL;
                acc_q   <= acc_q - STEP_V;
                steps_q <= '0;
            end
            if (st_q == SQ_CENTRE) begin
                ofs_q <= centre_v;
            end
        end
    end

    assign offset_o = ofs_q;

    // R11: offset holds unless a write strobe was given
    p_offset_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !offset_wr |=> $stable(offset_o));

    // R12: terminal indications are exclusive
    p_done_fail_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R9: the step budget is never exceeded
    p_step_budget_r9: assert property (@(posedge clk) disable iff (!rst_n)
        steps_q <= MAX_STEPS_V);

    // R3: a clear pulse is never issued together with a write
    p_clr_not_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_clr, offset_wr}));

endmodule

// File: tb/skew_edge_finder_tb.sv
module skew_edge_finder_tb;

    localparam int PW     = 12;
    localparam int P      = 1 << PW;
    localparam int STEP   = 8;
    localparam int STABLE = 10;
    localparam int SETTLE = 3;
    localparam int ACCUM  = 2;
    localparam int MAXS   = P / STEP;
    localparam int NV     = 5;

    // lo, hi, glitch offset (-1 none), inject start mid-run
    localparam int VEC [NV][4] = '{
        '{32'hA00, 32'hE00, -1,       1},  // R4 R5 R6 R8 R10 plain window
        '{32'h300, 32'h700, 32'h308,  0},  // R6 slide after glitch
        '{32'hE00, 32'h200, -1,       0},  // R8 wrapping window
        '{32'h800, 32'hC00, 32'h020,  0},  // R4 hunt reset by glitch
        '{0,       0,       -1,       0}   // R9 flag never rises
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          err_flag;
    logic          err_clr, offset_wr, busy, done, fail;
    logic [PW-1:0] offset_o;

    int checks = 0;
    int errors = 0;
    int cfg_lo = 0, cfg_hi = 0, cfg_gl = -1;
    int wofs = 0;
    int wr_idx = 0, wr_bad = 0, clr_cnt = 0, gap = 0, gap_bad = 0;
    int base = 0;
    int exp_nr = 0, exp_nf = 0, exp_lastr = 0, exp_centre = 0;
    bit timed_out = 0;

    always #5 clk = ~clk;

    skew_edge_finder #(
        .PERIOD_W(PW), .STEP(STEP), .STABLE(STABLE),
        .SETTLE_CYC(SETTLE), .ACCUM_CYC(ACCUM)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .err_flag(err_flag),
        .err_clr(err_clr), .offset_wr(offset_wr), .offset_o(offset_o),
        .busy(busy), .done(done), .fail(fail)
    );

    function automatic bit err_of(int w, int lo, int hi, int gl);
        bit in;
        if (lo <= hi) in = (w >= lo) && (w < hi);
        else          in = (w >= lo) || (w < hi);
        if (w == gl) in = !in;
        return in;
    endfunction

    always_comb err_flag = err_of(wofs, cfg_lo, cfg_hi, cfg_gl);

    function automatic int modp(int x);
        return ((x % P) + P) % P;
    endfunction

    function automatic int exp_write(int k);
        if (k < exp_nr) return modp(k * STEP);
        if (k < exp_nr + exp_nf) return modp(exp_lastr + (k - exp_nr) * STEP);
        return exp_centre;
    endfunction

    // Reference search from the requirements (R4 R5 R6 R9)
    task automatic model_search(input int st, input bit tgt, output bit found,
                                output int edge_v, output int last, output int nwr);
        int ofs = st;
        int s = 0;
        int cnt = 0;
        found = 0; edge_v = 0; last = st; nwr = 0;
        for (int i = 0; i < MAXS; i++) begin
            bit e;
            e = err_of(modp(ofs), cfg_lo, cfg_hi, cfg_gl);
            last = ofs;
            nwr++;
            ofs += STEP;
            if (s == 0) begin
                if (e != tgt) cnt++; else cnt = 0;
                if (cnt >= STABLE) begin s = 1; cnt = 0; end
            end else if (s == 1) begin
                if (e == tgt) begin s = 2; edge_v = ofs; end
            end else begin
                if (e != tgt) begin edge_v += STEP; cnt = 0; end
                else cnt++;
                if (cnt >= STABLE) begin found = 1; return; end
            end
        end
    endtask

    // Monitor of writes and clear pulses
    bit wr_pend = 0;
    always @(negedge clk) begin
        if (wr_pend) begin
            wofs = int'(offset_o);
            if (wofs != exp_write(wr_idx - base)) wr_bad++;
            wr_idx++;
        end
        wr_pend = offset_wr;
        if (err_clr) clr_cnt++;
        if (offset_wr) gap = 0;
        else begin
            gap++;
            if (err_clr && gap != SETTLE + 2) gap_bad++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic run_case(input int v);
        bit fr, ff, ok;
        int er, ef, lr, lf, nr, nf, w, b0, c0, g0, wb0, guard, hold;
        cfg_lo = VEC[v][0]; cfg_hi = VEC[v][1]; cfg_gl = VEC[v][2];
        model_search(0, 1'b1, fr, er, lr, nr);
        nf = 0; ff = 0; ef = 0; lf = 0;
        if (fr) model_search(lr, 1'b0, ff, ef, lf, nf);
        ok = fr && ff;
        w = P - (ef - er);
        exp_nr = nr; exp_nf = nf; exp_lastr = lr;
        exp_centre = modp(ef + w / 2);
        @(negedge clk);
        base = wr_idx; b0 = wr_idx; c0 = clr_cnt; g0 = gap_bad; wb0 = wr_bad;
        pulse_start();
        // R11: restart clears terminal flags, busy rises
        check(busy && !done && !fail, "R11", "status after start",
              {busy, done, fail}, 3'b100);
        if (VEC[v][3] != 0) begin
            repeat (40) @(negedge clk);
            pulse_start();  // R10: ignored while busy
        end
        guard = 0;
        while (!(done || fail) && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 40000) timed_out = 1;
        repeat (2) @(negedge clk);
        check(done == ok && fail == !ok, "R8/R9", "outcome done,fail",
              {done, fail}, {ok, !ok});
        if (ok) check(int'(offset_o) == exp_centre, "R8", "final offset",
                      int'(offset_o), exp_centre);
        check(wr_idx - b0 == nr + nf + (ok ? 1 : 0), "R7", "write count",
              wr_idx - b0, nr + nf + (ok ? 1 : 0));
        check(wr_bad == wb0, VEC[v][3] != 0 ? "R10" : "R2/R7", "offset sequence mismatches",
              wr_bad - wb0, 0);
        check(clr_cnt - c0 == nr + nf, "R3", "clear pulses", clr_cnt - c0, nr + nf);
        check(gap_bad == g0, "R3", "settle gap errors", gap_bad - g0, 0);
        hold = int'(offset_o);
        repeat (30) @(negedge clk);
        check(int'(offset_o) == hold && done == ok && fail == !ok && !offset_wr,
              "R11", "held result", int'(offset_o), hold);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy && !done && !fail && !offset_wr && !err_clr, "R1", "status after reset",
              {busy, done, fail, offset_wr, err_clr}, 0);
        check(offset_o == '0, "R1", "offset after reset", int'(offset_o), 0);
        for (int v = 0; v < NV; v++) begin
            if (!timed_out) run_case(v);
        end
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish actual=1 expected=0");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule